// File: doc/BRIEF.md
# Dual-Flavour Pseudo-Random Shift Register

This block produces a pseudo-random bit stream from a linear feedback shift register. A parameter chooses its structure at build time. One choice is an internal-XOR (Galois) register that shifts right. The other is an external-XNOR (Fibonacci) register that shifts left. The feedback taps come from a coefficient parameter.

Each enabled clock advances the register by one step. A client can mix extra randomness into the low bits of each step. It can also overwrite the whole register with a seed of its own. The low bits of the register are presented at the output. A fixed bit shuffle can be applied to them first, which breaks up the visible shifting pattern.

Each flavour has one dead state that the register would never leave: all zeros for XOR and all ones for XNOR. If the register lands in that state through a seed or through entropy, the next enabled step replaces it with the default seed.

Top module: `prng_shift_reg`

## Requirements
- R1: With `FLAVOR` = FB_GALOIS_XOR, one step maps state s to (s >> 1) XOR (s[0] ? TAPS : 0). With FB_FIBO_XNOR, one step maps s to {s[W-2:0], XNOR-reduce(s & TAPS)}.
- R2: While `rst_n` is low at a rising clock edge, the state is loaded with `INIT_SEED` at that edge. The reset is synchronous.
- R3: With `seed_load` low and `step_en` low, the state holds its value, whatever `entropy` is.
- R4: With `seed_load` high, the state takes `seed_val` at the next edge. This overrides stepping, entropy and lockup recovery.
- R5: The lockup value is all zeros for XOR and all ones for XNOR. If the state equals it, an enabled step without a seed load loads `INIT_SEED`, and entropy is not applied.
- R6: A seed equal to the lockup value is loaded as given. The following enabled step then replaces it with `INIT_SEED`.
- R7: On a normal enabled step, `entropy` is XORed into bits [ENT_W-1:0] of the R1 next state.
- R8: `rand_out` bit i equals state bit i when `PERM_ON` = 0. When `PERM_ON` = 1, it equals state bit PERM_MAP[i*IDX_W +: IDX_W], with IDX_W = clog2(WIDTH).
- R9: With entropy zero and no seed load, a step never moves a state that is not locked into the lockup value. Elaboration checks enforce the conditions for this: TAPS MSB is 1, an even tap count for XNOR, and INIT_SEED different from the lockup value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load `seed_val` into the state (highest priority) |
| seed_val | input | WIDTH | Seed to load |
| step_en | input | 1 | Advance the register by one step |
| entropy | input | ENT_W | Bits XORed into the low bits of the next state |
| rand_out | output | OUT_W | Low bits of the (optionally permuted) state |

## Verification
The assertions check four things on every cycle: the seed load, holding while idle, lockup recovery, and that no lockup arises from zero-entropy stepping. The exact step arithmetic of each flavour, the entropy mixing and the output permutation are shown only by the bench. It compares the output against its own model, on one instance of each flavour. The scenarios it drives include a lockup value loaded as a seed, a seed load made while the register is locked, and a reset in the middle of a run.

// File: rtl/prng_pkg.sv
// Package: shared types for the pseudo-random shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package prng_pkg;

    // Feedback structure selector
    typedef enum logic {
        FB_GALOIS_XOR = 1'b0,
        FB_FIBO_XNOR  = 1'b1
    } fb_kind_e;

endpackage

// File: rtl/prng_step.sv
// Module: prng_step
// Computes the plain next state of the register for the chosen flavour.
// Assumes: TAPS[WIDTH-1] is 1 (checked in the top); WIDTH >= 3.
module prng_step
    import prng_pkg::*;
#(
    parameter fb_kind_e          FLAVOR = FB_GALOIS_XOR,
    parameter int unsigned       WIDTH  = 32,
    parameter logic [WIDTH-1:0]  TAPS   = 32'h8020_0003
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] next_o
);

    generate
        if (FLAVOR == FB_GALOIS_XOR) begin : g_galois
            // Right shift; fold the taps in when a one leaves the bottom
            always_comb begin
                next_o = {1'b0, state_i[WIDTH-1:1]} ^ (state_i[0] ? TAPS : '0);
            end
        end else begin : g_fibo
            // Left shift; insert the XNOR of the tapped bits at the bottom
            always_comb begin
                next_o = {state_i[WIDTH-2:0], ~(^(state_i & TAPS))};
            end
        end
    endgenerate

endmodule

// File: rtl/prng_lock_det.sv
// Module: prng_lock_det
// Flags the dead state of the chosen flavour (all zeros / all ones).
// Assumes: purely combinational; the top decides what to do with the flag.
module prng_lock_det
    import prng_pkg::*;
#(
    parameter fb_kind_e    FLAVOR = FB_GALOIS_XOR,
    parameter int unsigned WIDTH  = 32
) (
    input  logic [WIDTH-1:0] state_i,
    output logic             locked_o
);

    localparam logic [WIDTH-1:0] DEAD_VAL = (FLAVOR == FB_GALOIS_XOR) ? '0 : '1;

    // Compare the state against the dead value
    always_comb begin
        locked_o = (state_i == DEAD_VAL);
    end

endmodule

// File: rtl/prng_out_map.sv
// Module: prng_out_map
// Selects the output bits, optionally through a constant bit shuffle.
// Assumes: PERM_MAP holds WIDTH entries of IDX_W bits, entry i at
//          [i*IDX_W +: IDX_W]; it is only used when PERM_ON is 1.
module prng_out_map #(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned OUT_W   = 8,
    parameter bit          PERM_ON = 1'b0,
    parameter int unsigned IDX_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    parameter logic [WIDTH*IDX_W-1:0] PERM_MAP = '0
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [OUT_W-1:0] out_o
);

    generate
        for (genvar i = 0; i < OUT_W; i++) begin : g_bit
            if (PERM_ON) begin : g_perm
                localparam logic [IDX_W-1:0] SRC = PERM_MAP[i*IDX_W +: IDX_W];
                // Route the mapped state bit to output bit i
                assign out_o[i] = state_i[SRC];
            end else begin : g_direct
                // Pass state bit i straight through
                assign out_o[i] = state_i[i];
            end
        end
    endgenerate

    // Elaboration check: every position appears exactly once in the map
    initial begin
        if (PERM_ON) begin
            for (int j = 0; j < int'(WIDTH); j++) begin
                int hits;
                hits = 0;
                for (int i = 0; i < int'(WIDTH); i++) begin
                    if (int'(PERM_MAP[i*IDX_W +: IDX_W]) == j) hits++;
                end
                assert_perm_complete_R8: assert (hits == 1)
                    else $error("permutation position %0d used %0d times", j, hits);
            end
        end
    end

endmodule

// File: rtl/prng_shift_reg.sv
// Module: prng_shift_reg (top)
// Pseudo-random shift register with seed load, entropy mixing, lockup
// recovery and an optional output shuffle.
// Assumes: synchronous active-low reset; ENT_W and OUT_W not above WIDTH.
module prng_shift_reg
    import prng_pkg::*;
#(
    parameter fb_kind_e          FLAVOR    = FB_GALOIS_XOR,
    parameter int unsigned       WIDTH     = 32,
    parameter int unsigned       ENT_W     = 8,
    parameter int unsigned       OUT_W     = 8,
    parameter logic [WIDTH-1:0]  INIT_SEED = WIDTH'(1),
    parameter logic [WIDTH-1:0]  TAPS      = 32'h8020_0003,
    parameter bit                PERM_ON   = 1'b0,
    parameter int unsigned       IDX_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1,
    parameter logic [WIDTH*IDX_W-1:0] PERM_MAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_val,
    input  logic             step_en,
    input  logic [ENT_W-1:0] entropy,
    output logic [OUT_W-1:0] rand_out
);

    localparam logic [WIDTH-1:0] DEAD_VAL = (FLAVOR == FB_GALOIS_XOR) ? '0 : '1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] step_nxt;
    logic [WIDTH-1:0] mixed_nxt;
    logic             locked;

    prng_step #(.FLAVOR(FLAVOR), .WIDTH(WIDTH), .TAPS(TAPS)) u_step (
        .state_i (state_q),
        .next_o  (step_nxt)
    );

    prng_lock_det #(.FLAVOR(FLAVOR), .WIDTH(WIDTH)) u_lock (
        .state_i  (state_q),
        .locked_o (locked)
    );

    prng_out_map #(
        .WIDTH(WIDTH), .OUT_W(OUT_W), .PERM_ON(PERM_ON),
        .IDX_W(IDX_W), .PERM_MAP(PERM_MAP)
    ) u_out (
        .state_i (state_q),
        .out_o   (rand_out)
    );

    // Mix entropy into the low bits of the stepped state
    always_comb begin
        mixed_nxt = step_nxt ^ WIDTH'(entropy);
    end

    // State register: reset, then seed load, then lockup recovery, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_SEED;
        end else if (seed_load) begin
            state_q <= seed_val;
        end else if (step_en) begin
            state_q <= locked ? INIT_SEED : mixed_nxt;
        end
    end

    // Elaboration checks on the parameter set
    initial begin
        assert_msb_tap_R9: assert (TAPS[WIDTH-1] == 1'b1)
            else $error("top coefficient bit must be set");
        assert_seed_live_R9: assert (INIT_SEED != DEAD_VAL)
            else $error("default seed equals the lockup value");
        assert_even_taps_R9: assert (FLAVOR == FB_GALOIS_XOR || ($countones(TAPS) % 2) == 0)
            else $error("XNOR flavour needs an even tap count");
        assert_ent_width_R7: assert (ENT_W <= WIDTH && ENT_W >= 1)
            else $error("entropy width out of range");
        assert_out_width_R8: assert (OUT_W <= WIDTH && OUT_W >= 1)
            else $error("output width out of range");
    end

    // A seed load lands in the state one edge later
    assert_seed_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && seed_load) |=> (state_q == $past(seed_val)));

    // Idle cycles leave the state untouched
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !seed_load && !step_en) |=> $stable(state_q));

    // A locked state is replaced by the default seed on the next step
    assert_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en && !seed_load && locked) |=> (state_q == INIT_SEED));

    // Plain stepping without entropy never creates a lockup
    assert_no_lockup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en && !seed_load && (entropy == '0) && !locked) |=> !locked);

endmodule

// File: tb/prng_shift_reg_test.sv
// Bench: one Galois XOR instance (defaults) and one Fibonacci XNOR instance
// with a rotating output permutation, both checked against bench models.
module prng_shift_reg_test;
    import prng_pkg::*;

    localparam logic [31:0] TAPS_A = 32'h8020_0003;
    localparam logic [15:0] TAPS_B = 16'hD008;

    function automatic logic [63:0] rot_map();
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 16; i++) m[i*4 +: 4] = 4'((i + 5) % 16);
        return m;
    endfunction
    localparam logic [63:0] MAP_B = rot_map();

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sl_a, sl_b, st_a, st_b;
    logic [31:0] sd_a;
    logic [15:0] sd_b;
    logic [7:0]  en_a;
    logic [3:0]  en_b;
    logic [7:0]  out_a;
    logic [15:0] out_b;

    logic [31:0] m_a;
    logic [15:0] m_b;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prng_shift_reg uut (
        .clk(clk), .rst_n(rst_n), .seed_load(sl_a), .seed_val(sd_a),
        .step_en(st_a), .entropy(en_a), .rand_out(out_a)
    );

    prng_shift_reg #(
        .FLAVOR(FB_FIBO_XNOR), .WIDTH(16), .ENT_W(4), .OUT_W(16),
        .INIT_SEED(16'h0001), .TAPS(TAPS_B), .PERM_ON(1'b1), .PERM_MAP(MAP_B)
    ) uut_xnor (
        .clk(clk), .rst_n(rst_n), .seed_load(sl_b), .seed_val(sd_b),
        .step_en(st_b), .entropy(en_b), .rand_out(out_b)
    );

    // R1 reference steps
    function automatic logic [31:0] gal_step(logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS_A : 32'h0);
    endfunction
    function automatic logic [15:0] xnr_step(logic [15:0] s);
        return {s[14:0], ~(^(s & TAPS_B))};
    endfunction
    // R8 reference shuffle
    function automatic logic [15:0] perm_b(logic [15:0] s);
        logic [15:0] o;
        for (int i = 0; i < 16; i++) o[i] = s[(i + 5) % 16];
        return o;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic r, logic la, logic [31:0] da, logic sa, logic [7:0] ea,
                       logic lb, logic [15:0] db, logic sb, logic [3:0] eb, string tag);
        @(negedge clk);
        rst_n = r; sl_a = la; sd_a = da; st_a = sa; en_a = ea;
        sl_b = lb; sd_b = db; st_b = sb; en_b = eb;
        @(posedge clk);
        if (!r) m_a = 32'h1;
        else if (la) m_a = da;
        else if (sa) m_a = (m_a == 32'h0) ? 32'h1 : (gal_step(m_a) ^ {24'h0, ea});
        if (!r) m_b = 16'h1;
        else if (lb) m_b = db;
        else if (sb) m_b = (m_b == 16'hFFFF) ? 16'h1 : (xnr_step(m_b) ^ {12'h0, eb});
        #1;
        check({tag, " xor"}, {24'h0, out_a}, {24'h0, m_a[7:0]});
        check({tag, " xnor"}, {16'h0, out_b}, {16'h0, perm_b(m_b)});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_a = 32'h1; m_b = 16'h1;
        // R2 reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 1, 32'h55, 1, 8'hFF, 1, 16'h55, 1, 4'hF, "R2");
        check("R2 xnor reset image", {16'h0, out_b}, 32'h0000_0800);
        // R1 plain stepping
        for (int i = 0; i < 40; i++) cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, "R1");
        // R3 hold with entropy toggling
        for (int i = 0; i < 8; i++)
            cyc(1, 0, 0, 0, 8'($urandom), 0, 0, 0, 4'($urandom), "R3");
        // R4 seed load wins over step and entropy
        cyc(1, 1, 32'hA5A5_1234, 1, 8'h3C, 1, 16'hBEEF, 1, 4'h9, "R4");
        // R6 load the lockup value, then step recovers
        cyc(1, 1, 32'h0, 1, 8'h11, 1, 16'hFFFF, 1, 4'h2, "R6");
        cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, "R6");
        // R5 locked plus entropy: entropy ignored, default seed loaded
        cyc(1, 1, 32'h0, 0, 0, 1, 16'hFFFF, 0, 0, "R5");
        cyc(1, 0, 0, 0, 8'h77, 0, 0, 0, 4'h7, "R5");
        cyc(1, 0, 0, 1, 8'h77, 0, 0, 1, 4'h7, "R5");
        // R4 seed load beats lockup recovery
        cyc(1, 1, 32'h0, 0, 0, 1, 16'hFFFF, 0, 0, "R4");
        cyc(1, 1, 32'hDEAD_0042, 1, 8'h01, 1, 16'h1357, 1, 4'h1, "R4");
        // R7 entropy mixing
        for (int i = 0; i < 200; i++)
            cyc(1, 0, 0, 1, 8'($urandom), 0, 0, 1, 4'($urandom), "R7");
        // R8 permutation across many states
        for (int i = 0; i < 60; i++) cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, "R8");
        // R2 reset in the middle of a run
        cyc(0, 0, 0, 1, 8'h5A, 0, 0, 1, 4'h5, "R2");
        // R9 long zero-entropy run with occasional seeds
        for (int i = 0; i < 3000; i++) begin
            logic ld, sp;
            logic [31:0] r32;
            r32 = $urandom;
            ld = (($urandom % 50) == 0);
            sp = (($urandom % 5) != 0);
            cyc(1, ld, r32 | 32'h1, sp, 0, ld, r32[15:0] & 16'h7FFF, sp, 0, "R9");
            check("R9 xnor not locked", {31'h0, out_b == 16'hFFFF}, 32'h0);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule